// File: doc/BRIEF.md
# PFC Fault Protection Sequencer

This block decides when the switch of a boost power-factor-correction stage may be driven. Analog comparators outside the block watch the supply rail, the bulk-sense divider and a separate overvoltage divider. Their digital results arrive here as level flags. From those flags the block produces a gate-enable, a soft-start request, a standby indication and a pull-high command for the current-loop compensation node.

A sequencer with six states arbitrates all faults. A supply drop always wins and parks the stage in OFF. An open sense loop sends it to STANDBY. The two overvoltage detectors each have a blanking window and set/clear hysteresis. They lead either to a hold, after which switching resumes directly, or to a restart that passes through soft start again. When both detectors trip together, both must clear before switching resumes.

All pins are plain level signals sampled on the rising clock edge. There is no data stream and no handshake.

Top module: `pfc_fault_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the state is OFF (`state_oh` = 6'b000001) and `gate_en`, `softstart_req` and `standby` are all low.
- R2: In OFF the block stays in OFF while `vcc_on_lvl` is low. With `vcc_on_lvl` high, the next edge moves it to SOFTSTART (bit 2) if `sense_live` is high, or to STANDBY (bit 1) if `sense_live` is low.
- R3: Outside OFF, a low `vcc_off_lvl` moves the block to OFF at the next edge, and `gate_en` is then low.
- R4: `sense_live` low for OLP_CYC consecutive edges moves the block to STANDBY at the following edge. A shorter low pulse has no effect, because the count restarts from zero.
- R5: In STANDBY, `gate_en` is low and `standby` and `comp_pull_hi` are high. The first edge with `sense_live` high moves the block to SOFTSTART. `comp_pull_hi` is also high in OFF.
- R6: SOFTSTART (bit 2, `gate_en` and `softstart_req` high) moves to RUN (bit 3, `gate_en` high, `softstart_req` low) only on an edge where `bulk_near` is high.
- R7: `ovp1_set` high for OVP_CYC consecutive edges, with `ovp2` not tripped, moves SOFTSTART or RUN to OVP_HOLD (bit 4, gate low) at the following edge. The edge that samples `ovp1_clr` high returns the block to RUN with no soft start.
- R8: `ovp2_set` high for OVP_CYC consecutive edges, with ovp1 not tripped, moves the block to OVP_RESTART (bit 5, gate low). The block never goes from there straight to RUN: `ovp2_clr` high sends it to SOFTSTART.
- R9: When both detectors are tripped, the block holds in OVP_HOLD with the gate low until `ovp1_clr` and `ovp2_clr` are both high, and then goes to RUN.
- R10: In OVP_HOLD, `ovp1_set` falling while `ovp1_clr` is still low (inside the hysteresis band) keeps the block in OVP_HOLD.
- R11: `state_oh` always has exactly one bit set.
- R12: Two `ovp1_set` pulses of OVP_CYC-1 edges each, separated by one low edge, do not trip the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_lvl | input | 1 | Supply above turn-on level |
| vcc_off_lvl | input | 1 | Supply above turn-off level |
| sense_live | input | 1 | Bulk-sense pin above open-loop level |
| ovp1_set | input | 1 | Bulk-sense above first overvoltage set level |
| ovp1_clr | input | 1 | Bulk-sense below first overvoltage clear level |
| ovp2_set | input | 1 | Second divider above its set level |
| ovp2_clr | input | 1 | Second divider below its clear level |
| bulk_near | input | 1 | Output at or above 95% of rated value |
| gate_en | output | 1 | Switching permitted |
| softstart_req | output | 1 | Soft start active |
| standby | output | 1 | Standby state |
| comp_pull_hi | output | 1 | Force compensation node to its high rail |
| state_oh | output | 6 | One-hot state: bit0 OFF, bit1 STANDBY, bit2 SOFTSTART, bit3 RUN, bit4 OVP_HOLD, bit5 OVP_RESTART |

## Verification
Every state is visible on `state_oh`, so a wrong transition shows at the ports one edge after the cause. A blanking counter that is off by one moves the fault entry one edge early or late, and the bench samples exactly at the boundary edge. A lost joint-overvoltage flag shows as RUN appearing while `ovp2_clr` is still low, one edge after `ovp1_clr` rises. A corrupted state encoding breaks the one-hot property at once.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  localparam int NST       = 6;
  localparam int S_OFF     = 0;
  localparam int S_STBY    = 1;
  localparam int S_SOFT    = 2;
  localparam int S_RUN     = 3;
  localparam int S_HOLD    = 4;
  localparam int S_RESTART = 5;

  typedef logic [NST-1:0] st_vec_t;

  function automatic st_vec_t st_bit(input int idx);
    st_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pfc_blank_timer.sv
// Trip flag rises after the condition is sampled high on CYCLES consecutive
// edges; any low sample restarts the count from zero.
module pfc_blank_timer #(
  parameter int unsigned CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic tripped
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMV = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!cond)       cnt_q <= '0;
    else if (cnt_q != LIMV) cnt_q <= cnt_q + 1'b1;
  end

  assign tripped = (cnt_q == LIMV);
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
  import pfc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    vcc_on_lvl,
  input  logic    vcc_off_lvl,
  input  logic    sense_live,
  input  logic    olp_trip,
  input  logic    ovp1_trip,
  input  logic    ovp2_trip,
  input  logic    ovp1_clr,
  input  logic    ovp2_clr,
  input  logic    bulk_near,
  output st_vec_t state_oh
);
  st_vec_t st_q, st_d;
  logic    dual_q, dual_d;

  always_comb begin
    st_d   = st_q;
    dual_d = dual_q;
    if (st_q[S_OFF]) begin
      if (vcc_on_lvl) st_d = sense_live ? st_bit(S_SOFT) : st_bit(S_STBY);
    end else if (!vcc_off_lvl) begin
      st_d = st_bit(S_OFF);
    end else if (olp_trip && !st_q[S_STBY]) begin
      st_d = st_bit(S_STBY);
    end else if (st_q[S_STBY]) begin
      if (sense_live) st_d = st_bit(S_SOFT);
    end else if (st_q[S_SOFT] || st_q[S_RUN]) begin
      if (ovp1_trip) begin
        st_d   = st_bit(S_HOLD);
        dual_d = ovp2_trip;
      end else if (ovp2_trip) begin
        st_d = st_bit(S_RESTART);
      end else if (st_q[S_SOFT] && bulk_near) begin
        st_d = st_bit(S_RUN);
      end
    end else if (st_q[S_HOLD]) begin
      if (ovp2_trip) dual_d = 1'b1;
      if (ovp1_clr && (!dual_q || ovp2_clr)) st_d = st_bit(S_RUN);
    end else if (st_q[S_RESTART]) begin
      if (ovp1_trip) begin
        st_d   = st_bit(S_HOLD);
        dual_d = 1'b1;
      end else if (ovp2_clr) begin
        st_d = st_bit(S_SOFT);
      end
    end
    if (!st_d[S_HOLD]) dual_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= st_bit(S_OFF);
      dual_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dual_q <= dual_d;
    end
  end

  assign state_oh = st_q;
endmodule

// File: rtl/pfc_out_decode.sv
module pfc_out_decode
  import pfc_seq_pkg::*;
(
  input  st_vec_t state_oh,
  output logic    gate_en,
  output logic    softstart_req,
  output logic    standby,
  output logic    comp_pull_hi
);
  assign gate_en       = state_oh[S_SOFT] | state_oh[S_RUN];
  assign softstart_req = state_oh[S_SOFT];
  assign standby       = state_oh[S_STBY];
  assign comp_pull_hi  = state_oh[S_STBY] | state_oh[S_OFF];
endmodule

// File: rtl/pfc_fault_seq.sv
module pfc_fault_seq
  import pfc_seq_pkg::*;
#(
  parameter int unsigned OLP_CYC = 100,
  parameter int unsigned OVP_CYC = 1200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vcc_on_lvl,
  input  logic           vcc_off_lvl,
  input  logic           sense_live,
  input  logic           ovp1_set,
  input  logic           ovp1_clr,
  input  logic           ovp2_set,
  input  logic           ovp2_clr,
  input  logic           bulk_near,
  output logic           gate_en,
  output logic           softstart_req,
  output logic           standby,
  output logic           comp_pull_hi,
  output logic [NST-1:0] state_oh
);
  localparam int NFLT = 3;

  logic [NFLT-1:0] flt_cond, flt_trip;
  assign flt_cond = {ovp2_set, ovp1_set, ~sense_live};

  for (genvar g = 0; g < NFLT; g++) begin : g_blank
    localparam int unsigned LIM = (g == 0) ? OLP_CYC : OVP_CYC;
    pfc_blank_timer #(.CYCLES(LIM)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (flt_cond[g]),
      .tripped (flt_trip[g])
    );
  end

  pfc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcc_on_lvl  (vcc_on_lvl),
    .vcc_off_lvl (vcc_off_lvl),
    .sense_live  (sense_live),
    .olp_trip    (flt_trip[0]),
    .ovp1_trip   (flt_trip[1]),
    .ovp2_trip   (flt_trip[2]),
    .ovp1_clr    (ovp1_clr),
    .ovp2_clr    (ovp2_clr),
    .bulk_near   (bulk_near),
    .state_oh    (state_oh)
  );

  pfc_out_decode u_dec (
    .state_oh      (state_oh),
    .gate_en       (gate_en),
    .softstart_req (softstart_req),
    .standby       (standby),
    .comp_pull_hi  (comp_pull_hi)
  );
endmodule

// File: rtl/pfc_fault_seq_chk.sv
module pfc_fault_seq_chk
  import pfc_seq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           vcc_on_lvl,
  input logic           vcc_off_lvl,
  input logic           sense_live,
  input logic           ovp1_set,
  input logic           ovp1_clr,
  input logic           ovp2_set,
  input logic           ovp2_clr,
  input logic           bulk_near,
  input logic           gate_en,
  input logic           softstart_req,
  input logic           standby,
  input logic           comp_pull_hi,
  input logic [NST-1:0] state_oh
);
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);

  a_r2_off_needs_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[S_OFF] && !vcc_on_lvl |=> state_oh[S_OFF]);

  a_r3_uvlo_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_off_lvl && !vcc_on_lvl |=> state_oh[S_OFF] && !gate_en);

  a_r5_standby_waits: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[S_STBY] && !sense_live && vcc_off_lvl |=> state_oh[S_STBY]);

  a_r6_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[S_SOFT] && !bulk_near |=> !state_oh[S_RUN]);

  a_r7_hold_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[S_HOLD] && !ovp1_clr |=> !gate_en);

  a_r8_restart_via_soft: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[S_RESTART] |=> !state_oh[S_RUN]);
endmodule

bind pfc_fault_seq pfc_fault_seq_chk u_chk (.*);

// File: tb/pfc_fault_seq_bench.sv
module pfc_fault_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OLP_N = 8;
  localparam int OVP_N = 20;
  localparam logic [5:0] ST_OFF = 6'b000001, ST_STBY = 6'b000010,
    ST_SOFT = 6'b000100, ST_RUN = 6'b001000, ST_HOLD = 6'b010000,
    ST_RESTART = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on_lvl = 1'b0, vcc_off_lvl = 1'b0, sense_live = 1'b0;
  logic ovp1_set = 1'b0, ovp1_clr = 1'b1, ovp2_set = 1'b0, ovp2_clr = 1'b1;
  logic bulk_near = 1'b0;
  logic gate_en, softstart_req, standby, comp_pull_hi;
  logic [5:0] state_oh;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_fault_seq #(.OLP_CYC(OLP_N), .OVP_CYC(OVP_N)) u_pfc_fault_seq (
    .clk(clk), .rst_n(rst_n), .vcc_on_lvl(vcc_on_lvl), .vcc_off_lvl(vcc_off_lvl),
    .sense_live(sense_live), .ovp1_set(ovp1_set), .ovp1_clr(ovp1_clr),
    .ovp2_set(ovp2_set), .ovp2_clr(ovp2_clr), .bulk_near(bulk_near),
    .gate_en(gate_en), .softstart_req(softstart_req), .standby(standby),
    .comp_pull_hi(comp_pull_hi), .state_oh(state_oh));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_st(input string req, input logic [5:0] exp);
    n_chk++;
    if (state_oh !== exp || $countones(state_oh) != 1) begin
      n_fail++;
      $display("FAIL %s: state_oh act=%b exp=%b", req, state_oh, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s act=%b exp=%b", req, nm, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(2);
    chk_st("R1", ST_OFF);
    chk_bit("R1", "gate_en", gate_en, 1'b0);
    chk_bit("R1", "softstart_req", softstart_req, 1'b0);
    chk_bit("R1", "standby", standby, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk_st("R1", ST_OFF);
  endtask

  task automatic t_powerup;
    vcc_off_lvl = 1'b1;
    tick(2);
    chk_st("R2", ST_OFF);
    sense_live = 1'b1; vcc_on_lvl = 1'b1;
    tick(1);
    chk_st("R2", ST_SOFT);
    chk_bit("R2", "gate_en", gate_en, 1'b1);
    chk_bit("R6", "softstart_req", softstart_req, 1'b1);
    tick(4);
    chk_st("R6", ST_SOFT);
    bulk_near = 1'b1;
    tick(1);
    chk_st("R6", ST_RUN);
    chk_bit("R6", "softstart_req", softstart_req, 1'b0);
    chk_bit("R6", "gate_en", gate_en, 1'b1);
  endtask

  task automatic t_ovp1;
    ovp1_set = 1'b1; ovp1_clr = 1'b0;
    tick(OVP_N);
    chk_st("R7", ST_RUN);
    tick(1);
    chk_st("R7", ST_HOLD);
    chk_bit("R7", "gate_en", gate_en, 1'b0);
    ovp1_set = 1'b0;
    tick(5);
    chk_st("R10", ST_HOLD);
    ovp1_clr = 1'b1;
    tick(1);
    chk_st("R7", ST_RUN);
    chk_bit("R7", "softstart_req", softstart_req, 1'b0);
  endtask

  task automatic t_glitch;
    ovp1_set = 1'b1;
    tick(OVP_N - 1);
    ovp1_set = 1'b0;
    tick(1);
    ovp1_set = 1'b1;
    tick(OVP_N - 1);
    ovp1_set = 1'b0;
    tick(2);
    chk_st("R12", ST_RUN);
    sense_live = 1'b0;
    tick(OLP_N - 1);
    sense_live = 1'b1;
    tick(3);
    chk_st("R4", ST_RUN);
  endtask

  task automatic t_ovp2;
    ovp2_set = 1'b1; ovp2_clr = 1'b0;
    tick(OVP_N + 1);
    chk_st("R8", ST_RESTART);
    chk_bit("R8", "gate_en", gate_en, 1'b0);
    ovp2_set = 1'b0;
    tick(3);
    chk_st("R8", ST_RESTART);
    ovp2_clr = 1'b1;
    tick(1);
    chk_st("R8", ST_SOFT);
    chk_bit("R8", "softstart_req", softstart_req, 1'b1);
    tick(1);
    chk_st("R6", ST_RUN);
  endtask

  task automatic t_both;
    ovp1_set = 1'b1; ovp1_clr = 1'b0;
    ovp2_set = 1'b1; ovp2_clr = 1'b0;
    tick(OVP_N + 1);
    chk_st("R9", ST_HOLD);
    ovp1_set = 1'b0; ovp1_clr = 1'b1;
    tick(3);
    chk_st("R9", ST_HOLD);
    chk_bit("R9", "gate_en", gate_en, 1'b0);
    ovp2_set = 1'b0;
    tick(2);
    chk_st("R9", ST_HOLD);
    ovp2_clr = 1'b1;
    tick(1);
    chk_st("R9", ST_RUN);
  endtask

  task automatic t_olp;
    sense_live = 1'b0;
    tick(OLP_N);
    chk_st("R4", ST_RUN);
    tick(1);
    chk_st("R4", ST_STBY);
    chk_bit("R5", "gate_en", gate_en, 1'b0);
    chk_bit("R5", "standby", standby, 1'b1);
    chk_bit("R5", "comp_pull_hi", comp_pull_hi, 1'b1);
    tick(3);
    chk_st("R5", ST_STBY);
    sense_live = 1'b1;
    tick(1);
    chk_st("R5", ST_SOFT);
    tick(1);
    chk_st("R6", ST_RUN);
  endtask

  task automatic t_uvlo;
    vcc_off_lvl = 1'b0; vcc_on_lvl = 1'b0;
    tick(1);
    chk_st("R3", ST_OFF);
    chk_bit("R3", "gate_en", gate_en, 1'b0);
    vcc_off_lvl = 1'b1;
    tick(3);
    chk_st("R2", ST_OFF);
    sense_live = 1'b0; vcc_on_lvl = 1'b1;
    tick(1);
    chk_st("R2", ST_STBY);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_powerup();
    t_ovp1();
    t_glitch();
    t_ovp2();
    t_both();
    t_olp();
    t_uvlo();
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule